// File: doc/BRIEF.md
# Secondary Bus Reset and Parking Sequencer

This block produces the reset sequence for a downstream parallel bus. It asserts an active-low secondary reset for a fixed number of secondary clock cycles. A short fixed delay after the reset goes active, it parks the 32-bit address/data lines, the 4-bit command/byte-enable lines and the parity line at zero. One cycle after the reset is released, it hands those lines back, so they can float.

Over the last cycles of every reset pulse, the block drives the 64-bit request line low. Attached devices sample this line to learn how wide their data path is. A strobe covering the same cycles tells the pattern logic when to broadcast the bus initialization pattern. All timing comes from one down-counter on the secondary clock, so the real durations scale with the clock period.

A sequence starts when the primary reset is released, or on any cycle where the software request input is sampled high. A request that arrives while a sequence is running reloads the counter.

Top module: `sbus_reset_seq`

## Requirements
- R1: While `rst_n` is low, `sec_rst_n` is low and `park_oe`, `pattern_win` and `req64_oe` are low. After `rst_n` is released, `sec_rst_n` goes high at the RST_CYCLES-th rising edge (default 32), counting the first edge with `rst_n` high as edge 1.
- R2: If `sw_req` is sampled high at edge k and there is no later request, `sec_rst_n` is low from edge k and goes high at edge k+RST_CYCLES.
- R3: A request sampled while the reset is already asserted restarts the count. The reset then ends RST_CYCLES edges after the last request.
- R4: `park_oe` goes high exactly PARK_DLY edges (default 2) after `sec_rst_n` falls, and stays high while the reset stays asserted.
- R5: `park_oe` goes low at the edge after the edge where `sec_rst_n` rises.
- R6: Whenever `park_oe` is high, `ad_o`, `cbe_o` and `par_o` are all zero.
- R7: `pattern_win` and `req64_oe` are high, and `req64_n` is low, only while `sec_rst_n` is low. They cover exactly the last WIN_CYCLES cycles (default 12, at least 10) before `sec_rst_n` rises.
- R8: `reset_active` is always the inverse of `sec_rst_n`.
- R9: A request that lands inside the request-line window closes the window at once. The window opens again WIN_CYCLES cycles before the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| rst_n | input | 1 | Primary reset, active low, asynchronous |
| sw_req | input | 1 | Software bus reset request, sampled each cycle |
| sec_rst_n | output | 1 | Secondary bus reset, active low |
| reset_active | output | 1 | High while the secondary reset is asserted |
| park_oe | output | 1 | Output enable for the parked address/data, command and parity lines |
| ad_o | output | 32 | Parked address/data value |
| cbe_o | output | 4 | Parked command/byte-enable value |
| par_o | output | 1 | Parked parity value |
| req64_oe | output | 1 | Drive enable for the 64-bit request line |
| req64_n | output | 1 | 64-bit request line value, active low |
| pattern_win | output | 1 | Strobe marking the initialization pattern broadcast window |

## Verification
The hardest cases to reach are the timing collisions between two requests.

- A second request can land inside the request-line window.
- A second request can land on the exact edge of release.
- A second request can come one or two cycles after release, while the parking delay line still holds stale state.

To cover these, the stimulus issues one request and then a second one at every offset from 1 to 40 cycles later. Every cycle is compared against a model in the bench that counts cycles since the last request.

// File: rtl/sbus_reset_seq.sv
module sbus_reset_seq #(
  parameter int RST_CYCLES = 32,
  parameter int WIN_CYCLES = 12,
  parameter int PARK_DLY   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_req,
  output logic        sec_rst_n,
  output logic        reset_active,
  output logic        park_oe,
  output logic [31:0] ad_o,
  output logic [3:0]  cbe_o,
  output logic        par_o,
  output logic        req64_oe,
  output logic        req64_n,
  output logic        pattern_win
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0]       cnt;
  logic [PARK_DLY-1:0] dly;
  logic                active;
  logic                win;

  assign active = (cnt != '0);
  assign win    = active && (cnt <= CW'(WIN_CYCLES));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= CW'(RST_CYCLES);
    else if (sw_req) cnt <= CW'(RST_CYCLES);
    else if (active) cnt <= cnt - 1'b1;

  generate
    if (PARK_DLY == 1) begin : g_dly1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dly <= '0;
        else        dly <= active;
    end else begin : g_dlyn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dly <= '0;
        else        dly <= {dly[PARK_DLY-2:0], active};
    end
  endgenerate

  assign sec_rst_n    = !active;
  assign reset_active = active;
  assign park_oe      = &dly;
  assign ad_o         = '0;
  assign cbe_o        = '0;
  assign par_o        = 1'b0;
  assign req64_oe     = win;
  assign req64_n      = !win;
  assign pattern_win  = win;
endmodule

module sbus_reset_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_req,
  input logic        sec_rst_n,
  input logic        reset_active,
  input logic        park_oe,
  input logic [31:0] ad_o,
  input logic [3:0]  cbe_o,
  input logic        par_o,
  input logic        req64_oe,
  input logic        req64_n,
  input logic        pattern_win
);
  p_active_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_active != sec_rst_n);

  p_fall_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_rst_n) |-> $past(sw_req));

  p_park_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_rst_n) |=> !park_oe ##1 park_oe);

  p_park_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_rst_n) |-> park_oe ##1 !park_oe);

  p_park_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    park_oe |-> (ad_o == '0 && cbe_o == '0 && !par_o));

  p_win_in_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_win |-> (!sec_rst_n && req64_oe && !req64_n));

  p_win_before_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_rst_n) |-> $past(pattern_win));
endmodule

bind sbus_reset_seq sbus_reset_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sec_rst_n(sec_rst_n),
  .reset_active(reset_active), .park_oe(park_oe), .ad_o(ad_o), .cbe_o(cbe_o),
  .par_o(par_o), .req64_oe(req64_oe), .req64_n(req64_n), .pattern_win(pattern_win)
);

// File: tb/sim_sbus_reset_seq.sv
module sim_sbus_reset_seq;
  localparam int RC = 32;
  localparam int WC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_req = 1'b0;
  logic sec_rst_n, reset_active, park_oe, par_o, req64_oe, req64_n, pattern_win;
  logic [31:0] ad_o;
  logic [3:0]  cbe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    since;
  logic  cur_a, prev_a, exp_oe, exp_a;
  string rtag;

  always #5 clk = ~clk;

  sbus_reset_seq u0 (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sec_rst_n(sec_rst_n),
    .reset_active(reset_active), .park_oe(park_oe), .ad_o(ad_o), .cbe_o(cbe_o),
    .par_o(par_o), .req64_oe(req64_oe), .req64_n(req64_n), .pattern_win(pattern_win)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    logic ew;
    ew = exp_a && (since >= RC - WC);
    chk(rtag, sec_rst_n, !exp_a);
    chk("R8 reset_active", reset_active, exp_a);
    chk("R4/R5 park_oe", park_oe, exp_oe);
    if (park_oe) chk("R6 parked zero", {ad_o[31:1], ad_o[0] | par_o | (|cbe_o)}, 32'd0);
    // R9: restart inside the window is covered by the same window model
    chk("R7 pattern_win", pattern_win, ew);
    chk("R7 req64_oe", req64_oe, ew);
    chk("R7 req64_n", req64_n, !ew);
  endtask

  task automatic step(input logic r);
    sw_req = r;
    @(posedge clk);
    since  = r ? 0 : ((since > 1000) ? since : since + 1);
    exp_oe = cur_a & prev_a;
    prev_a = cur_a;
    cur_a  = (since < RC);
    exp_a  = cur_a;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held during primary reset
    chk("R1 sec_rst_n in reset", sec_rst_n, 1'b0);
    chk("R1 park_oe in reset", park_oe, 1'b0);
    chk("R1 pattern_win in reset", pattern_win, 1'b0);
    chk("R1 req64_oe in reset", req64_oe, 1'b0);
    rst_n = 1'b1;
    since = 0; cur_a = 1'b1; prev_a = 1'b0;
    rtag = "R1 power-on release";
    repeat (40) step(1'b0);

    rtag = "R2 single request";
    step(1'b1);
    repeat (40) step(1'b0);

    rtag = "R3 restart sweep";
    for (int d = 1; d <= 40; d++) begin
      step(1'b1);
      repeat (d - 1) step(1'b0);
      step(1'b1);
      repeat (40) step(1'b0);
    end

    rtag = "R3 held request";
    for (int h = 2; h <= 6; h++) begin
      repeat (h) step(1'b1);
      repeat (40) step(1'b0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule